// File: doc/BRIEF.md
# AM Envelope Demodulator with Bus-Programmable Slicer

The block turns a stream of 8-bit signed samples into a single data bit. Each valid sample enters a four-tap band-pass FIR with 17-bit fixed-point coefficients. The filter output is scaled back to sample range and rectified, so the stage produces the envelope magnitude. A recursive moving average over the last eight magnitudes smooths that envelope. A slicer then compares the average with a threshold and gives the output bit.

A microcontroller sets the decision level at run time. It writes the threshold through a Wishbone B4 classic slave port and can read it back. Every pipeline stage moves only when a sample is valid, so the output bit keeps its value between samples. The clock runs at 100 MHz or more, which leaves a wide margin over the sample rates needed for data at 10, 40 and 80 kbit/s.

Top module: `am_env_demod`

## Requirements
- R1: After reset, `bit_o` is 0, `wb_ack_o` is 0, the threshold reads back as 128 and the filter history, average storage and running sum are all zero.
- R2: With the default coefficients {+0.5, +0.25, -0.25, -0.5} in Q1.16 (0x08000, 0x04000, 0x1C000, 0x18000), applied from the newest sample to the oldest, the filter value is floor((2*x0 + x1 - x2 - 2*x3) / 4).
- R3: A negative filter value contributes its magnitude to the average, in the same way as a positive value of equal size.
- R4: The average is floor(S / 8), where S is the sum of the last eight magnitudes. Each valid sample adds its new magnitude to S and removes the oldest one.
- R5: `bit_o` is 1 only when the average is strictly greater than the threshold. When the two are equal, `bit_o` is 0.
- R6: A sample taken on rising edge N is reflected on `bit_o` after edge N+3. Cycles where `sample_vld_i` is low change no stored state, and the value on `sample_i` in those cycles has no effect.
- R7: A write at byte offset 0 with `wb_sel_i[0]` set loads `wb_dat_i[7:0]` into the threshold. `wb_ack_o` is high for exactly one cycle, in the cycle after the request (`wb_cyc_i` and `wb_stb_i` both high).
- R8: A read at offset 0 returns the threshold in `wb_dat_o[7:0]` with zeros above, in the same cycle as the acknowledge.
- R9: A write to any offset other than 0, or a write with `wb_sel_i[0]` low, is acknowledged but leaves the threshold unchanged. A read from another offset returns zero.
- R10: Asserting reset in the middle of a stream discards all filter and average history, so later results depend only on the samples that arrive after reset.
- R11: When a threshold write and an average update take effect on the same edge, the next value of `bit_o` uses both the new average and the new threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 8 | Signed input sample |
| sample_vld_i | input | 1 | Sample strobe |
| bit_o | output | 1 | Demodulated data bit |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 4 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_sel_i | input | 4 | Byte lane selects |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |

## Verification
A threshold write and an average update can land on the same clock edge. The slicer compares continuously, so its next decision must use both new values. The bench provokes this by placing a bus write two edges after a sample is captured, which is the edge where that sample reaches the running sum. The chosen values make the expected bit 1 only for the new-average, new-threshold pair: the old average against the new threshold gives 0, and the new average against the old threshold also gives 0. The scoreboard checks that bit at the pipeline latency along with every other result.

// File: rtl/am_demod_pkg.sv
package am_demod_pkg;
  localparam int unsigned SAMPLE_W  = 8;
  localparam int unsigned COEF_W    = 17;
  localparam int unsigned TAPS      = 4;
  localparam int unsigned FRAC_W    = 16;
  localparam int unsigned MAG_W     = 8;
  localparam int unsigned AVG_DEPTH = 8;
  localparam int unsigned WB_ADR_W  = 4;
  localparam int unsigned WB_DW     = 32;

  // index 0 weights the newest sample
  localparam logic [TAPS-1:0][COEF_W-1:0] DEF_COEFS =
    {17'h18000, 17'h1C000, 17'h04000, 17'h08000};
endpackage

// File: rtl/am_bpf_fir.sv
module am_bpf_fir #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned COEF_W   = 17,
  parameter int unsigned TAPS     = 4,
  parameter logic [TAPS-1:0][COEF_W-1:0] COEFS = '0,
  localparam int unsigned PROD_W  = SAMPLE_W + COEF_W,
  localparam int unsigned ACC_W   = PROD_W + $clog2(TAPS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       vld_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       vld_o,
  output logic signed [ACC_W-1:0]    acc_o
);
  logic signed [SAMPLE_W-1:0] dly_q [TAPS];
  logic signed [PROD_W-1:0]   prod  [TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) dly_q[k] <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        dly_q[0] <= sample_i;
        for (int k = 1; k < TAPS; k++) dly_q[k] <= dly_q[k-1];
      end
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [COEF_W-1:0] coef;
    assign coef    = $signed(COEFS[k]);
    assign prod[k] = dly_q[k] * coef;
  end

  always_comb begin
    acc_o = '0;
    for (int k = 0; k < TAPS; k++)
      acc_o = acc_o + {{(ACC_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
  end
endmodule

// File: rtl/am_env_rect.sv
module am_env_rect #(
  parameter int unsigned ACC_W  = 27,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned MAG_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic                    vld_o,
  output logic [MAG_W-1:0]        mag_o
);
  localparam logic signed [ACC_W-1:0] LIM = ACC_W'(2**MAG_W - 1);

  logic signed [ACC_W-1:0] scaled;
  logic signed [ACC_W-1:0] mag_abs;
  logic [MAG_W-1:0]        mag_d;

  assign scaled  = acc_i >>> FRAC_W;
  assign mag_abs = scaled[ACC_W-1] ? -scaled : scaled;
  assign mag_d   = (mag_abs > LIM) ? '1 : mag_abs[MAG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) mag_o <= mag_d;
    end
  end
endmodule

// File: rtl/am_mavg.sv
module am_mavg #(
  parameter int unsigned MAG_W = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SH    = $clog2(DEPTH),
  localparam int unsigned SUM_W = MAG_W + SH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [SUM_W-1:0] sum_o,
  output logic [MAG_W-1:0] avg_o
);
  logic [MAG_W-1:0] fifo_q [DEPTH];
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) fifo_q[k] <= '0;
      sum_q <= '0;
    end else if (vld_i) begin
      fifo_q[0] <= mag_i;
      for (int k = 1; k < DEPTH; k++) fifo_q[k] <= fifo_q[k-1];
      sum_q <= sum_q + SUM_W'(mag_i) - SUM_W'(fifo_q[DEPTH-1]);
    end
  end

  assign sum_o = sum_q;
  assign avg_o = sum_q[SUM_W-1:SH];
endmodule

// File: rtl/am_wb_thresh.sv
module am_wb_thresh #(
  parameter int unsigned ADR_W = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned THR_W = 8,
  parameter logic [THR_W-1:0] THR_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [ADR_W-1:0] adr_i,
  input  logic [DW-1:0]    dat_i,
  input  logic [DW/8-1:0]  sel_i,
  output logic [DW-1:0]    dat_o,
  output logic             ack_o,
  output logic [THR_W-1:0] thr_o
);
  logic req, hit;
  logic unused_bits;

  assign req = cyc_i & stb_i & ~ack_o;
  assign hit = (adr_i == '0);
  assign unused_bits = ^{dat_i[DW-1:THR_W], sel_i[DW/8-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o <= 1'b0;
      dat_o <= '0;
      thr_o <= THR_RST;
    end else begin
      ack_o <= req;
      if (req) begin
        dat_o <= hit ? DW'(thr_o) : '0;
        if (we_i && hit && sel_i[0]) thr_o <= dat_i[THR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/am_env_demod.sv
module am_env_demod
  import am_demod_pkg::*;
#(
  parameter int unsigned SMP_W  = SAMPLE_W,
  parameter int unsigned CF_W   = COEF_W,
  parameter int unsigned NTAPS  = TAPS,
  parameter int unsigned FRAC   = FRAC_W,
  parameter int unsigned ENV_W  = MAG_W,
  parameter int unsigned DEPTH  = AVG_DEPTH,
  parameter int unsigned ADR_W  = WB_ADR_W,
  parameter int unsigned DW     = WB_DW,
  parameter logic [NTAPS-1:0][CF_W-1:0] COEFS = DEF_COEFS,
  localparam int unsigned ACC_W = SMP_W + CF_W + $clog2(NTAPS),
  localparam int unsigned SUM_W = ENV_W + $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] sample_i,
  input  logic             sample_vld_i,
  output logic             bit_o,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [DW-1:0]    wb_dat_i,
  input  logic [DW/8-1:0]  wb_sel_i,
  output logic [DW-1:0]    wb_dat_o,
  output logic             wb_ack_o
);
  localparam logic [ENV_W-1:0] THR_RST = ENV_W'(2**(ENV_W-1));

  logic                    fir_vld, mag_vld;
  logic signed [ACC_W-1:0] fir_acc;
  logic [ENV_W-1:0]        mag, avg, thr_q;
  logic [SUM_W-1:0]        sum;

  am_bpf_fir #(.SAMPLE_W(SMP_W), .COEF_W(CF_W), .TAPS(NTAPS), .COEFS(COEFS)) u_fir (
    .clk_i, .rst_ni,
    .vld_i(sample_vld_i), .sample_i($signed(sample_i)),
    .vld_o(fir_vld), .acc_o(fir_acc)
  );

  am_env_rect #(.ACC_W(ACC_W), .FRAC_W(FRAC), .MAG_W(ENV_W)) u_rect (
    .clk_i, .rst_ni,
    .vld_i(fir_vld), .acc_i(fir_acc),
    .vld_o(mag_vld), .mag_o(mag)
  );

  am_mavg #(.MAG_W(ENV_W), .DEPTH(DEPTH)) u_mavg (
    .clk_i, .rst_ni,
    .vld_i(mag_vld), .mag_i(mag),
    .sum_o(sum), .avg_o(avg)
  );

  am_wb_thresh #(.ADR_W(ADR_W), .DW(DW), .THR_W(ENV_W), .THR_RST(THR_RST)) u_wb (
    .clk_i, .rst_ni,
    .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .we_i(wb_we_i),
    .adr_i(wb_adr_i), .dat_i(wb_dat_i), .sel_i(wb_sel_i),
    .dat_o(wb_dat_o), .ack_o(wb_ack_o), .thr_o(thr_q)
  );

  // slicer compares every cycle so a new threshold applies at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_o <= 1'b0;
    else         bit_o <= (avg > thr_q);
  end
endmodule

// File: rtl/am_env_demod_chk.sv
module am_env_demod_chk #(
  parameter int unsigned ADR_W = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned ENV_W = 8,
  parameter int unsigned SUM_W = 11,
  parameter int unsigned DEPTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wb_cyc_i,
  input logic             wb_stb_i,
  input logic             wb_we_i,
  input logic [ADR_W-1:0] wb_adr_i,
  input logic [DW-1:0]    wb_dat_i,
  input logic [DW/8-1:0]  wb_sel_i,
  input logic             wb_ack_o,
  input logic [ENV_W-1:0] thr_q,
  input logic [SUM_W-1:0] sum,
  input logic             mag_vld
);
  localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(DEPTH * (2**ENV_W - 1));

  logic req, wr_hit;
  assign req    = wb_cyc_i && wb_stb_i && !wb_ack_o;
  assign wr_hit = req && wb_we_i && (wb_adr_i == '0) && wb_sel_i[0];

  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> wb_ack_o); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o); // R7
  AST_ACK_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_ack_o) |-> $past(wb_cyc_i && wb_stb_i)); // R7
  AST_THR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> thr_q == $past(wb_dat_i[ENV_W-1:0])); // R7
  AST_THR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(thr_q)); // R9
  AST_SUM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mag_vld |=> $stable(sum)); // R6
  AST_SUM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum <= SUM_MAX); // R4
endmodule

bind am_env_demod am_env_demod_chk #(
  .ADR_W(ADR_W), .DW(DW), .ENV_W(ENV_W), .SUM_W(SUM_W), .DEPTH(DEPTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
  .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_sel_i(wb_sel_i),
  .wb_ack_o(wb_ack_o), .thr_q(thr_q), .sum(sum), .mag_vld(mag_vld)
);

// File: tb/tb_am_env_demod.sv
module tb_am_env_demod;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sample = '0;
  logic        vld = 1'b0;
  logic        bit_out;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [3:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [3:0]  sel = '0;
  logic [31:0] rdat;
  logic        ack;

  int n_chk = 0, n_fail = 0;

  typedef struct { logic exp; int req; } item_t;
  item_t q[$];

  int hist[4];
  int mags[8];
  int thr_m = 128;
  logic [3:0] vsh;
  int alt_sign = 1;

  always #5 clk = ~clk;

  am_env_demod dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_vld_i(vld),
    .bit_o(bit_out), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_sel_i(sel),
    .wb_dat_o(rdat), .wb_ack_o(ack)
  );

  task automatic chk(input bit ok, input int req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 4; k++) hist[k] = 0;
    for (int k = 0; k < 8; k++) mags[k] = 0;
  endtask

  // R2 R3 R4 R5: reference pipeline
  task automatic model_push(input int s, input int req);
    int raw, y, m, sum;
    item_t it;
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = s;
    raw = 2*hist[0] + hist[1] - hist[2] - 2*hist[3];
    y = raw >>> 2;
    m = (y < 0) ? -y : y;
    if (m > 255) m = 255;
    for (int k = 7; k > 0; k--) mags[k] = mags[k-1];
    mags[0] = m;
    sum = 0;
    for (int k = 0; k < 8; k++) sum += mags[k];
    it.exp = ((sum >> 3) > thr_m);
    it.req = req;
    q.push_back(it);
  endtask

  task automatic send(input int s, input int idle, input int req);
    @(negedge clk);
    vld = 1'b1; sample = s[7:0];
    model_push(s, req);
    if (idle > 0) begin
      @(negedge clk);
      vld = 1'b0; sample = 8'($urandom);
      repeat (idle - 1) @(negedge clk);
    end
  endtask

  task automatic idle_n(input int n);
    @(negedge clk);
    vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_alt(input int a, input int idle, input int req);
    send(alt_sign * a, idle, req);
    alt_sign = -alt_sign;
  endtask

  task automatic wb_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a; wdat = d; sel = s;
    @(negedge clk);
    chk(ack == 1'b1, 7, ack, 1); // R7 ack one cycle after request
    cyc = 0; stb = 0; we = 0;
    if (a == 4'd0 && s[0]) thr_m = int'(d[7:0]);
    @(negedge clk);
    chk(ack == 1'b0, 7, ack, 0); // R7 single pulse
  endtask

  task automatic wb_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a; sel = 4'hF;
    @(negedge clk);
    chk(ack == 1'b1, 8, ack, 1); // R8
    d = rdat;
    cyc = 0; stb = 0;
    @(negedge clk);
  endtask

  // scoreboard monitor: result due three edges after the capture edge (R6)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) vsh <= '0;
    else        vsh <= {vsh[2:0], vld};
  end

  always @(negedge clk) begin
    if (rst_n && vsh[3]) begin
      if (q.size() == 0) begin
        chk(1'b0, 6, 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(bit_out == it.exp, it.req, bit_out, it.exp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic held;
    model_clear();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bit_out == 1'b0, 1, bit_out, 0);
    chk(ack == 1'b0, 1, ack, 0);
    rst_n = 1'b1;
    wb_read(4'd0, rd);
    chk(rd == 32'd128, 1, rd, 128);

    // R7 R8 R9 register access
    wb_write(4'd0, 32'hFFFF_FF5A, 4'hF);
    wb_read(4'd0, rd);
    chk(rd == 32'h5A, 8, rd, 32'h5A);
    wb_write(4'd4, 32'h11, 4'hF);
    wb_read(4'd0, rd);
    chk(rd == 32'h5A, 9, rd, 32'h5A);
    wb_write(4'd0, 32'h22, 4'hE);
    wb_read(4'd0, rd);
    chk(rd == 32'h5A, 9, rd, 32'h5A);
    wb_read(4'd4, rd);
    chk(rd == 32'd0, 9, rd, 0);

    // R2 tap order with a positive impulse, back-to-back samples
    wb_write(4'd0, 32'd10, 4'h1);
    send(100, 0, 2);
    for (int i = 0; i < 10; i++) send(0, 0, 2);
    idle_n(8);
    // R3 negative impulse, sparse samples
    send(-128, 1, 3);
    for (int i = 0; i < 10; i++) send(0, 2, 3);
    idle_n(8);

    // R5 equality yields 0, one below yields 1
    wb_write(4'd0, 32'd30, 4'h1);
    for (int i = 0; i < 16; i++) send_alt(60, 0, 5);
    idle_n(8);
    wb_write(4'd0, 32'd29, 4'h1);
    for (int i = 0; i < 8; i++) send_alt(60, 0, 5);
    idle_n(8);

    // R6 idle cycles with noise on sample_i change nothing
    held = bit_out;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      vld = 1'b0; sample = 8'($urandom);
      chk(bit_out == held, 6, bit_out, held);
    end
    send_alt(60, 0, 6);
    idle_n(8);

    // R4 random streams under two thresholds
    wb_write(4'd0, 32'd40, 4'h1);
    for (int i = 0; i < 150; i++) send(int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 2)), 4);
    idle_n(8);
    wb_write(4'd0, 32'd12, 4'h1);
    for (int i = 0; i < 100; i++) send(int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 1)), 4);
    idle_n(8);

    // R10 load large history, reset mid-stream
    for (int i = 0; i < 12; i++) send_alt(127, 0, 10);
    idle_n(8);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bit_out == 1'b0, 10, bit_out, 0);
    rst_n = 1'b1;
    thr_m = 128;
    model_clear();
    alt_sign = 1;
    wb_read(4'd0, rd);
    chk(rd == 32'd128, 10, rd, 128);
    wb_write(4'd0, 32'd20, 4'h1);
    for (int i = 0; i < 4; i++) send_alt(60, 0, 10);
    idle_n(8);

    // R11 threshold write on the same edge as the average update
    wb_write(4'd0, 32'd128, 4'h1);
    for (int i = 0; i < 12; i++) send_alt(60, 0, 11);
    idle_n(8);
    thr_m = 32;
    send(127, 1, 11);
    wb_write(4'd0, 32'd32, 4'h1);
    idle_n(8);
    chk(q.size() == 0, 6, q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule